// File: doc/BRIEF.md
# Configuration Access Address Router

This block sits between a simple register-bus master and the configuration registers of a PCIe root port. The master presents one configuration request at a time: bus number, device, function, byte offset, a read/write flag and write data. The router decides whether the request is for the root port itself or for a device below it. It then loads the matching address register and performs one dword transfer through the matching data port. It finishes the request with a one-cycle done pulse that carries an error flag and the read data.

Requests on bus zero go to the root port through an indirect window. Only device 0, function 0 exists there. The byte offset is masked to a dword-aligned local address. Requests on any other bus produce a type-1 address word that packs bus, device, function and dword offset. A mode input restricts the downstream side to a single device. Rejected requests never touch an address register or a data port, and they return all-ones data.

Top module: `cfg_route_top`

## Requirements
- R1: After reset, req_ready is 1, rsp_done and rsp_err are 0, dp_rd and dp_wr are 0, and local_addr and remote_addr are 0.
- R2: A request with bus 0, device 0 and function 0 loads local_addr with req_off AND 0x1FFC (bits 12:2 kept, bits 1:0 cleared), then strobes the data port with dp_local = 1.
- R3: A request with bus 0 and a nonzero device or a nonzero function is rejected: no data-port strobe, neither address register changes, and the response has rsp_err = 1.
- R4: A request with a nonzero bus loads remote_addr with bus in bits 27:20, device in bits 19:15, function in bits 14:12, req_off bits 11:2 in bits 11:2, and the value 01 in bits 1:0. Offset bit 12 is dropped and bits 31:28 are 0. The data-port strobe then has dp_local = 0.
- R5: While single_dev_mode is 1, a request with a nonzero bus and a nonzero device is rejected as in R3. Device 0 with any function is still accepted. While single_dev_mode is 0, any device number is accepted on a nonzero bus.
- R6: A rejected request responds on the first cycle after acceptance, with rsp_rdata = 0xFFFFFFFF and rsp_err = 1.
- R7: An accepted read raises dp_rd for one cycle, and the response returns the dp_rdata value sampled in that cycle. An accepted write raises dp_wr for one cycle, with dp_wdata equal to req_wdata. The write response has rsp_rdata = 0 and rsp_err = 0.
- R8: For an accepted request, the address register is written at the acceptance edge. The single data strobe is in the next cycle, and rsp_done follows one cycle after the strobe, which is the second cycle after acceptance.
- R9: req_ready is 0 from acceptance until the response cycle. A req_valid raised in that span is ignored: it causes no extra strobe and does not change the address registers.
- R10: rsp_done is high for exactly one cycle per request, and rsp_err is high only together with rsp_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| single_dev_mode | input | 1 | Reject downstream devices other than 0 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Router idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_fn | input | 3 | Function number |
| req_off | input | 13 | Byte offset in configuration space |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request rejected (with rsp_done) |
| rsp_rdata | output | 32 | Read data, valid with rsp_done |
| local_addr | output | 13 | Root-port indirect address register |
| remote_addr | output | 32 | Downstream type-1 address register |
| dp_rd | output | 1 | Data-port read strobe |
| dp_wr | output | 1 | Data-port write strobe |
| dp_local | output | 1 | Strobe targets the root-port data port |
| dp_wdata | output | 32 | Data-port write data |
| dp_rdata | input | 32 | Data-port read data |

## Verification
The bench drives bus-zero requests to a nonzero device and to a nonzero function. A router that checked only the device would let function 2 through and write the indirect address register. Downstream requests use an offset with bit 12 set and low bits set, so a wrong mask would leak those bits into the type field or the register field. Mis-ordered field shifts would corrupt the bus bits near bit 27. Single-device mode is exercised with device 1 against device 0 function 7, which catches a design that also rejects nonzero functions. A request injected while busy would show up as a second strobe or as a changed address register if the ready logic were wrong.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

   typedef enum logic [1:0] {
      RT_REJECT = 2'd0,
      RT_LOCAL  = 2'd1,
      RT_REMOTE = 2'd2
   } cfgr_route_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DATA = 2'd1,
      ST_RESP = 2'd2
   } cfgr_state_e;

endpackage

// File: rtl/cfgr_decode.sv
module cfgr_decode
   import cfgr_pkg::*;
#(
   parameter int BUS_W  = 8,
   parameter int DEV_W  = 5,
   parameter int FN_W   = 3,
   parameter int OFF_W  = 13,
   parameter int ADDR_W = 32
) (
   input  logic [BUS_W-1:0]  bus,
   input  logic [DEV_W-1:0]  dev,
   input  logic [FN_W-1:0]   fn,
   input  logic [OFF_W-1:0]  off,
   input  logic              single_mode,
   output cfgr_route_e       route,
   output logic [OFF_W-1:0]  local_word,
   output logic [ADDR_W-1:0] remote_word
);
   // field placement of the type-1 word
   localparam int REG_MSB = 11;
   localparam int FN_LSB  = REG_MSB + 1;
   localparam int DEV_LSB = FN_LSB + FN_W;
   localparam int BUS_LSB = DEV_LSB + DEV_W;
   localparam int TOP_BIT = BUS_LSB + BUS_W;
   localparam logic [OFF_W-1:0] OFF_MASK = {{(OFF_W-2){1'b1}}, 2'b00};
   localparam logic [1:0] TYPE1 = 2'b01;

   logic [OFF_W-1:0] masked;
   assign masked     = off & OFF_MASK;
   assign local_word = masked;

   always_comb begin
      if (bus == '0) begin
         route = ((dev == '0) && (fn == '0)) ? RT_LOCAL : RT_REJECT;
      end else if (single_mode && (dev != '0)) begin
         route = RT_REJECT;
      end else begin
         route = RT_REMOTE;
      end
   end

   logic [TOP_BIT-1:0] packed_word;
   assign packed_word = {bus, dev, fn, masked[REG_MSB:2], TYPE1};

   generate
      if (ADDR_W > TOP_BIT) begin : g_pad
         assign remote_word = {{(ADDR_W-TOP_BIT){1'b0}}, packed_word};
      end else begin : g_exact
         assign remote_word = packed_word;
      end
   endgenerate

endmodule

// File: rtl/cfgr_addr_regs.sv
module cfgr_addr_regs #(
   parameter int OFF_W  = 13,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_local,
   input  logic              ld_remote,
   input  logic [OFF_W-1:0]  local_in,
   input  logic [ADDR_W-1:0] remote_in,
   output logic [OFF_W-1:0]  local_q,
   output logic [ADDR_W-1:0] remote_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         local_q  <= '0;
         remote_q <= '0;
      end else begin
         if (ld_local)  local_q  <= local_in;
         if (ld_remote) remote_q <= remote_in;
      end
   end
endmodule

// File: rtl/cfgr_seq.sv
module cfgr_seq
   import cfgr_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   input  cfgr_route_e       route_in,
   input  logic [DATA_W-1:0] dp_rdata,
   output logic              req_ready,
   output logic              ld_local,
   output logic              ld_remote,
   output logic              dp_rd,
   output logic              dp_wr,
   output logic              dp_local,
   output logic [DATA_W-1:0] dp_wdata,
   output logic              done,
   output logic              err,
   output logic [DATA_W-1:0] rdata
);
   cfgr_state_e       state_q;
   logic              write_q;
   logic              local_q;
   logic              err_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;
   logic              accept;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_ready && req_valid;
   assign ld_local  = accept && (route_in == RT_LOCAL);
   assign ld_remote = accept && (route_in == RT_REMOTE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         write_q <= 1'b0;
         local_q <= 1'b0;
         err_q   <= 1'b0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  write_q <= req_write;
                  wdata_q <= req_wdata;
                  local_q <= (route_in == RT_LOCAL);
                  if (route_in == RT_REJECT) begin
                     err_q   <= 1'b1;
                     rdata_q <= '1;
                     state_q <= ST_RESP;
                  end else begin
                     err_q   <= 1'b0;
                     rdata_q <= '0;
                     state_q <= ST_DATA;
                  end
               end
            end
            ST_DATA: begin
               if (!write_q) rdata_q <= dp_rdata;
               state_q <= ST_RESP;
            end
            ST_RESP: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign dp_rd    = (state_q == ST_DATA) && !write_q;
   assign dp_wr    = (state_q == ST_DATA) && write_q;
   assign dp_local = (state_q == ST_DATA) && local_q;
   assign dp_wdata = wdata_q;
   assign done     = (state_q == ST_RESP);
   assign err      = done && err_q;
   assign rdata    = rdata_q;

endmodule

// File: rtl/cfg_route_top.sv
module cfg_route_top
   import cfgr_pkg::*;
#(
   parameter int BUS_W  = 8,
   parameter int DEV_W  = 5,
   parameter int FN_W   = 3,
   parameter int OFF_W  = 13,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              single_dev_mode,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [BUS_W-1:0]  req_bus,
   input  logic [DEV_W-1:0]  req_dev,
   input  logic [FN_W-1:0]   req_fn,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_done,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [OFF_W-1:0]  local_addr,
   output logic [ADDR_W-1:0] remote_addr,
   output logic              dp_rd,
   output logic              dp_wr,
   output logic              dp_local,
   output logic [DATA_W-1:0] dp_wdata,
   input  logic [DATA_W-1:0] dp_rdata
);
   localparam int FIELD_BITS = BUS_W + DEV_W + FN_W + 12;

   generate
      if (FIELD_BITS > ADDR_W) begin : g_bad_addr_w
         $error("ADDR_W too narrow for bus/device/function/offset fields");
      end
      if (OFF_W < 12) begin : g_bad_off_w
         $error("OFF_W must cover the dword register field");
      end
   endgenerate

   cfgr_route_e       route;
   logic [OFF_W-1:0]  local_word;
   logic [ADDR_W-1:0] remote_word;
   logic              ld_local;
   logic              ld_remote;

   cfgr_decode #(
      .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W),
      .OFF_W(OFF_W), .ADDR_W(ADDR_W)
   ) u_decode (
      .bus         (req_bus),
      .dev         (req_dev),
      .fn          (req_fn),
      .off         (req_off),
      .single_mode (single_dev_mode),
      .route       (route),
      .local_word  (local_word),
      .remote_word (remote_word)
   );

   cfgr_addr_regs #(
      .OFF_W(OFF_W), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_local  (ld_local),
      .ld_remote (ld_remote),
      .local_in  (local_word),
      .remote_in (remote_word),
      .local_q   (local_addr),
      .remote_q  (remote_addr)
   );

   cfgr_seq #(
      .DATA_W(DATA_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_wdata (req_wdata),
      .route_in  (route),
      .dp_rdata  (dp_rdata),
      .req_ready (req_ready),
      .ld_local  (ld_local),
      .ld_remote (ld_remote),
      .dp_rd     (dp_rd),
      .dp_wr     (dp_wr),
      .dp_local  (dp_local),
      .dp_wdata  (dp_wdata),
      .done      (rsp_done),
      .err       (rsp_err),
      .rdata     (rsp_rdata)
   );

endmodule

// File: rtl/cfg_route_chk.sv
module cfg_route_chk #(
   parameter int BUS_W  = 8,
   parameter int DEV_W  = 5,
   parameter int FN_W   = 3,
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              single_dev_mode,
   input logic              req_valid,
   input logic              req_ready,
   input logic [BUS_W-1:0]  req_bus,
   input logic [DEV_W-1:0]  req_dev,
   input logic [FN_W-1:0]   req_fn,
   input logic              rsp_done,
   input logic              rsp_err,
   input logic [ADDR_W-1:0] remote_addr,
   input logic              dp_rd,
   input logic              dp_wr,
   input logic              dp_local
);
   logic accept;
   assign accept = req_valid && req_ready;

   // R3
   a_r3_local_reject: assert property (@(posedge clk) disable iff (!rst_n)
      accept && (req_bus == '0) && ((req_dev != '0) || (req_fn != '0))
      |=> rsp_done && rsp_err);

   // R4
   a_r4_type_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_rd || dp_wr) && !dp_local |-> remote_addr[1:0] == 2'b01);

   // R5
   a_r5_single_reject: assert property (@(posedge clk) disable iff (!rst_n)
      accept && single_dev_mode && (req_bus != '0) && (req_dev != '0)
      |=> rsp_done && rsp_err);

   // R7
   a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(dp_rd && dp_wr));

   // R8
   a_r8_strobe_then_done: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_rd || dp_wr) |=> rsp_done && !rsp_err);

   // R9
   a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_rd || dp_wr) |-> !req_ready);

   // R10
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_done);

endmodule

bind cfg_route_top cfg_route_chk #(
   .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .single_dev_mode (single_dev_mode),
   .req_valid       (req_valid),
   .req_ready       (req_ready),
   .req_bus         (req_bus),
   .req_dev         (req_dev),
   .req_fn          (req_fn),
   .rsp_done        (rsp_done),
   .rsp_err         (rsp_err),
   .remote_addr     (remote_addr),
   .dp_rd           (dp_rd),
   .dp_wr           (dp_wr),
   .dp_local        (dp_local)
);

// File: tb/tb_cfg_route_top.sv
module tb_cfg_route_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        single_dev_mode = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [7:0]  req_bus = '0;
   logic [4:0]  req_dev = '0;
   logic [2:0]  req_fn = '0;
   logic [12:0] req_off = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_done;
   logic        rsp_err;
   logic [31:0] rsp_rdata;
   logic [12:0] local_addr;
   logic [31:0] remote_addr;
   logic        dp_rd;
   logic        dp_wr;
   logic        dp_local;
   logic [31:0] dp_wdata;
   logic [31:0] dp_rdata = '0;

   int checks = 0;
   int failures = 0;

   // results of the last request
   int          r_lat;
   logic [31:0] r_rdata;
   logic        r_err;
   int          r_nrd;
   int          r_nwr;
   logic        r_local;
   logic [31:0] r_wdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_route_top dut (
      .clk(clk), .rst_n(rst_n), .single_dev_mode(single_dev_mode),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_bus(req_bus), .req_dev(req_dev), .req_fn(req_fn),
      .req_off(req_off), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .local_addr(local_addr), .remote_addr(remote_addr),
      .dp_rd(dp_rd), .dp_wr(dp_wr), .dp_local(dp_local),
      .dp_wdata(dp_wdata), .dp_rdata(dp_rdata)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] type1_word(input logic [7:0] b, input logic [4:0] d,
                                              input logic [2:0] f, input logic [12:0] o);
      return (32'(b) << 20) | (32'(d) << 15) | (32'(f) << 12) |
             (32'(o) & 32'h0000_0FFC) | 32'h1;
   endfunction

   // one request; optionally raises a second request while busy
   task automatic run_req(input logic [7:0] b, input logic [4:0] d, input logic [2:0] f,
                          input logic [12:0] o, input logic wr, input logic [31:0] wd,
                          input bit inject);
      int n;
      @(negedge clk);
      req_bus = b; req_dev = d; req_fn = f; req_off = o;
      req_write = wr; req_wdata = wd; req_valid = 1'b1;
      r_lat = 0; r_nrd = 0; r_nwr = 0; r_local = 1'b0; r_wdata = '0;
      r_err = 1'b0; r_rdata = '0;
      n = 0;
      while (n < 20) begin
         @(negedge clk);
         n++;
         if (inject && n == 1) begin
            req_bus = 8'h77; req_dev = 5'd9; req_fn = 3'd1; req_off = 13'h0FF0;
            req_write = 1'b1; req_valid = 1'b1;
         end else begin
            req_valid = 1'b0;
         end
         if (dp_rd) begin r_nrd++; r_local = dp_local; end
         if (dp_wr) begin r_nwr++; r_local = dp_local; r_wdata = dp_wdata; end
         if (rsp_done) begin
            r_lat = n; r_err = rsp_err; r_rdata = rsp_rdata;
            break;
         end
         chk(req_ready == 1'b0, "R9", "ready while busy", 32'(req_ready), 32'h0);
      end
      req_valid = 1'b0;
      @(negedge clk);
      chk(rsp_done == 1'b0 && rsp_err == 1'b0, "R10", "done/err after pulse",
          {30'h0, rsp_done, rsp_err}, 32'h0);
   endtask

   task automatic t_reset();
      chk(req_ready == 1'b1, "R1", "ready", 32'(req_ready), 32'h1);
      chk(rsp_done == 1'b0 && rsp_err == 1'b0, "R1", "done/err",
          {30'h0, rsp_done, rsp_err}, 32'h0);
      chk(dp_rd == 1'b0 && dp_wr == 1'b0, "R1", "strobes", {30'h0, dp_rd, dp_wr}, 32'h0);
      chk(local_addr == '0, "R1", "local_addr", 32'(local_addr), 32'h0);
      chk(remote_addr == '0, "R1", "remote_addr", remote_addr, 32'h0);
   endtask

   task automatic t_local_read();
      dp_rdata = 32'hCAFE_0001;
      run_req(8'h00, 5'd0, 3'd0, 13'h1ABF, 1'b0, 32'h0, 1'b0);
      chk(local_addr == 13'h1ABC, "R2", "local_addr mask", 32'(local_addr), 32'h1ABC);
      chk(r_nrd == 1 && r_nwr == 0, "R7", "one read strobe", 32'(r_nrd), 32'h1);
      chk(r_local == 1'b1, "R2", "dp_local", 32'(r_local), 32'h1);
      chk(r_rdata == 32'hCAFE_0001 && !r_err, "R7", "read data", r_rdata, 32'hCAFE_0001);
      chk(r_lat == 2, "R8", "latency legal", 32'(r_lat), 32'h2);
   endtask

   task automatic t_local_write();
      run_req(8'h00, 5'd0, 3'd0, 13'h0043, 1'b1, 32'h1234_5678, 1'b0);
      chk(local_addr == 13'h0040, "R2", "local_addr write", 32'(local_addr), 32'h40);
      chk(r_nwr == 1 && r_nrd == 0, "R7", "one write strobe", 32'(r_nwr), 32'h1);
      chk(r_wdata == 32'h1234_5678, "R7", "write data", r_wdata, 32'h1234_5678);
      chk(r_local == 1'b1, "R2", "dp_local write", 32'(r_local), 32'h1);
      chk(r_rdata == 32'h0 && !r_err, "R7", "write response", r_rdata, 32'h0);
   endtask

   task automatic t_local_reject();
      logic [12:0] la;
      logic [31:0] ra;
      la = local_addr; ra = remote_addr;
      run_req(8'h00, 5'd3, 3'd0, 13'h0100, 1'b0, 32'h0, 1'b0);
      chk(r_err == 1'b1, "R3", "bus0 dev3 err", 32'(r_err), 32'h1);
      chk(r_nrd + r_nwr == 0, "R3", "no strobe dev3", 32'(r_nrd + r_nwr), 32'h0);
      chk(r_rdata == 32'hFFFF_FFFF, "R6", "all-ones data", r_rdata, 32'hFFFF_FFFF);
      chk(r_lat == 1, "R6", "reject latency", 32'(r_lat), 32'h1);
      run_req(8'h00, 5'd0, 3'd2, 13'h0200, 1'b1, 32'hDEAD_BEEF, 1'b0);
      chk(r_err == 1'b1, "R3", "bus0 fn2 err", 32'(r_err), 32'h1);
      chk(r_nrd + r_nwr == 0, "R3", "no strobe fn2", 32'(r_nrd + r_nwr), 32'h0);
      chk(local_addr == la, "R3", "local_addr kept", 32'(local_addr), 32'(la));
      chk(remote_addr == ra, "R3", "remote_addr kept", remote_addr, ra);
   endtask

   task automatic t_remote();
      logic [31:0] exp;
      dp_rdata = 32'h0BAD_F00D;
      run_req(8'hA5, 5'h13, 3'd5, 13'h1FFF, 1'b0, 32'h0, 1'b0);
      exp = type1_word(8'hA5, 5'h13, 3'd5, 13'h1FFF);
      chk(remote_addr == exp, "R4", "type-1 word", remote_addr, exp);
      chk(r_local == 1'b0 && r_nrd == 1, "R4", "remote strobe", 32'(r_local), 32'h0);
      chk(r_rdata == 32'h0BAD_F00D, "R7", "remote read data", r_rdata, 32'h0BAD_F00D);
      run_req(8'h01, 5'h00, 3'd0, 13'h0004, 1'b1, 32'h5555_AAAA, 1'b0);
      exp = type1_word(8'h01, 5'h00, 3'd0, 13'h0004);
      chk(remote_addr == exp, "R4", "type-1 word small", remote_addr, exp);
      chk(r_wdata == 32'h5555_AAAA && r_nwr == 1, "R7", "remote write", r_wdata, 32'h5555_AAAA);
   endtask

   task automatic t_single_mode();
      logic [31:0] ra;
      logic [31:0] exp;
      single_dev_mode = 1'b1;
      ra = remote_addr;
      run_req(8'h02, 5'd1, 3'd0, 13'h0010, 1'b0, 32'h0, 1'b0);
      chk(r_err == 1'b1 && r_nrd == 0, "R5", "single dev1 rejected", 32'(r_err), 32'h1);
      chk(remote_addr == ra, "R5", "remote kept", remote_addr, ra);
      run_req(8'h02, 5'd0, 3'd7, 13'h0010, 1'b0, 32'h0, 1'b0);
      exp = type1_word(8'h02, 5'd0, 3'd7, 13'h0010);
      chk(r_err == 1'b0 && r_nrd == 1, "R5", "single dev0 fn7 ok", 32'(r_err), 32'h0);
      chk(remote_addr == exp, "R5", "single dev0 word", remote_addr, exp);
      single_dev_mode = 1'b0;
      run_req(8'h02, 5'd31, 3'd0, 13'h0010, 1'b0, 32'h0, 1'b0);
      exp = type1_word(8'h02, 5'd31, 3'd0, 13'h0010);
      chk(r_err == 1'b0 && remote_addr == exp, "R5", "mode off dev31 ok", remote_addr, exp);
   endtask

   task automatic t_busy_ignore();
      logic [31:0] exp;
      dp_rdata = 32'h1357_9BDF;
      run_req(8'h10, 5'd2, 3'd1, 13'h0080, 1'b0, 32'h0, 1'b1);
      exp = type1_word(8'h10, 5'd2, 3'd1, 13'h0080);
      chk(r_nrd == 1 && r_nwr == 0, "R9", "single strobe", 32'(r_nrd + r_nwr), 32'h1);
      chk(remote_addr == exp, "R9", "address not overwritten", remote_addr, exp);
      chk(r_lat == 2 && r_rdata == 32'h1357_9BDF, "R8", "busy latency/data", 32'(r_lat), 32'h2);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_local_read();
      t_local_write();
      t_local_reject();
      t_remote();
      t_single_mode();
      t_busy_ignore();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule